// File: doc/BRIEF.md
# Handshaked Parallel Port Cycle Engine

This block is the host side of an enhanced parallel port cycle engine. The host bus selects an address register or a data register and issues a read or a write. The block then runs the peripheral cycle in hardware, with no software stepping through the pins. It sets the direction line, drives the byte on writes, and pulses the strobe that belongs to the selected register. It watches the peripheral's wait line at each step.

The host access is stretched until the peripheral handshake has finished. The host holds its request and sees a one-cycle acknowledge at the end. Cycles run only while the mode-enable input is high. That input is raised after a successful negotiation, which takes place outside this block.

A watchdog counter ends any cycle that stalls. When it fires, the block releases the strobe, completes the host access with an error, and sets a sticky timeout bit. While that bit is set, every new peripheral cycle is refused. The host clears the bit by writing a 1 to bit 0 of the status register.

Top module: `ppx_cycle_engine`

## Requirements
- R1: After reset, both strobes and the write line are high, the data driver is off, and the acknowledge output is low. A status read (`hst_sel[1]`=1) then returns 0.
- R2: A host write to the address register (`hst_sel`=2'b00) pulses only the address strobe. During that cycle the write line is low and `pp_data_o` carries `hst_wdata`. The acknowledge then arrives with error low.
- R3: A host write to the data register (`hst_sel`=2'b01) pulses only the data strobe. The data strobe never goes low at the same time as the address strobe.
- R4: A host read leaves the write line high and the data driver off for the whole cycle. The byte on `pp_data_i` is captured when wait is seen high, and it is returned on `hst_rdata` with the acknowledge.
- R5: A strobe is asserted only after wait has been seen low. While wait stays high, no strobe is asserted and the host access does not complete.
- R6: The acknowledge comes only after the strobe has been released and wait has returned low. It is high for exactly one cycle.
- R7: While `mode_en` is low, a request to the address or data register is acknowledged with `hst_err`=1, and neither strobe is asserted.
- R8: If a cycle is still active after WDOG_CYCLES clocks, it is aborted. The strobes and the write line return high, and the acknowledge comes with `hst_err`=1 on the (WDOG_CYCLES+1)-th clock after the request was accepted. The timeout bit becomes 1.
- R9: The timeout bit is sticky and is read as bit 0 of the status register. While it is set, peripheral requests are acknowledged with `hst_err`=1 and no strobe. A status write with bit 0 = 1 clears it; a status write with bit 0 = 0 leaves it set.
- R10: A status register access is acknowledged on the first clock after it is accepted, without any peripheral activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_en | input | 1 | High once negotiation has succeeded; gates peripheral cycles |
| hst_req | input | 1 | Host request, held until acknowledged |
| hst_we | input | 1 | 1 = write, 0 = read |
| hst_sel | input | 2 | 00 address register, 01 data register, 1x status register |
| hst_wdata | input | 8 | Write byte |
| hst_ack | output | 1 | One-cycle completion pulse |
| hst_err | output | 1 | Valid with ack; 1 = refused or timed out |
| hst_rdata | output | 8 | Read byte, valid with ack |
| pp_data_i | input | 8 | Data bus as seen from the cable |
| pp_data_o | output | 8 | Data bus drive value |
| pp_data_oe | output | 1 | Data bus driver enable |
| pp_write_n | output | 1 | Write line, low for writes |
| pp_astb_n | output | 1 | Address strobe, active low |
| pp_dstb_n | output | 1 | Data strobe, active low |
| pp_wait | input | 1 | Peripheral wait/acknowledge |

## Verification
The main cycle is exercised with writes and reads to both registers. This separates the two strobes and checks the direction line and the driver. The peripheral response and release delays are varied, and wait is held high before the strobe, to show that each phase follows the handshake and not a fixed count of clocks. A peripheral that never answers measures the exact abort cycle. It is followed by requests with the enable low, requests with the timeout bit set, and clearing writes with bit 0 at both values, which tell refusal apart from a normal completion.

// File: rtl/ppx_pkg.sv
package ppx_pkg;
  localparam int PPX_DW = 8;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SETUP   = 3'd1,
    ST_STROBE  = 3'd2,
    ST_RELEASE = 3'd3,
    ST_ACK     = 3'd4
  } ppx_state_e;

  // status register image: bit 0 is the sticky timeout flag
  function automatic logic [PPX_DW-1:0] status_byte(input logic tmo);
    status_byte = {{(PPX_DW-1){1'b0}}, tmo};
  endfunction

  // counter width able to hold limit-1
  function automatic int cnt_width(input int limit);
    cnt_width = (limit > 2) ? $clog2(limit) : 1;
  endfunction
endpackage

// File: rtl/ppx_sync.sv
module ppx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh_q <= '0;
        else        sh_q <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d};
    end
  endgenerate

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/ppx_watchdog.sv
module ppx_watchdog #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  import ppx_pkg::*;
  localparam int CW = cnt_width(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run)           cnt_q <= '0;
    else if (cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
  end

  assign expire = run && (cnt_q == LAST);

  // R8: the count never passes the limit
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R8: a stopped watchdog restarts from zero
  a_r8_clear_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);
endmodule

// File: rtl/ppx_cycle_engine.sv
module ppx_cycle_engine #(
  parameter int WDOG_CYCLES = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_en,
  input  logic       hst_req,
  input  logic       hst_we,
  input  logic [1:0] hst_sel,
  input  logic [7:0] hst_wdata,
  output logic       hst_ack,
  output logic       hst_err,
  output logic [7:0] hst_rdata,
  input  logic [7:0] pp_data_i,
  output logic [7:0] pp_data_o,
  output logic       pp_data_oe,
  output logic       pp_write_n,
  output logic       pp_astb_n,
  output logic       pp_dstb_n,
  input  logic       pp_wait
);
  import ppx_pkg::*;

  ppx_state_e        state_q;
  logic              is_wr_q, is_addr_q, tmo_q, err_q;
  logic [PPX_DW-1:0] wdat_q, rdat_q;

  // named internal events
  logic wait_s, active, wd_expire, strobe_on;
  logic req_status, req_refused, req_start;

  ppx_sync #(.STAGES(SYNC_STAGES)) u_wait_sync (
    .clk(clk), .rst_n(rst_n), .d(pp_wait), .q(wait_s));

  assign active = (state_q == ST_SETUP) || (state_q == ST_STROBE) ||
                  (state_q == ST_RELEASE);

  ppx_watchdog #(.LIMIT(WDOG_CYCLES)) u_wdog (
    .clk(clk), .rst_n(rst_n), .run(active), .expire(wd_expire));

  assign req_status  = (state_q == ST_IDLE) && hst_req && hst_sel[1];
  assign req_refused = (state_q == ST_IDLE) && hst_req && !hst_sel[1] &&
                       (!mode_en || tmo_q);
  assign req_start   = (state_q == ST_IDLE) && hst_req && !hst_sel[1] &&
                       mode_en && !tmo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      is_wr_q   <= 1'b0;
      is_addr_q <= 1'b0;
      tmo_q     <= 1'b0;
      err_q     <= 1'b0;
      wdat_q    <= '0;
      rdat_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_status) begin
            rdat_q  <= status_byte(tmo_q);
            err_q   <= 1'b0;
            if (hst_we && hst_wdata[0]) tmo_q <= 1'b0;
            state_q <= ST_ACK;
          end else if (req_refused) begin
            rdat_q  <= '0;
            err_q   <= 1'b1;
            state_q <= ST_ACK;
          end else if (req_start) begin
            is_wr_q   <= hst_we;
            is_addr_q <= !hst_sel[0];
            wdat_q    <= hst_wdata;
            rdat_q    <= '0;
            err_q     <= 1'b0;
            state_q   <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (wd_expire) begin
            tmo_q <= 1'b1; err_q <= 1'b1; rdat_q <= '0; state_q <= ST_ACK;
          end else if (!wait_s) begin
            state_q <= ST_STROBE;
          end
        end
        ST_STROBE: begin
          if (wd_expire) begin
            tmo_q <= 1'b1; err_q <= 1'b1; rdat_q <= '0; state_q <= ST_ACK;
          end else if (wait_s) begin
            if (!is_wr_q) rdat_q <= pp_data_i;
            state_q <= ST_RELEASE;
          end
        end
        ST_RELEASE: begin
          if (wd_expire) begin
            tmo_q <= 1'b1; err_q <= 1'b1; rdat_q <= '0; state_q <= ST_ACK;
          end else if (!wait_s) begin
            state_q <= ST_ACK;
          end
        end
        ST_ACK:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign strobe_on  = (state_q == ST_STROBE);
  assign pp_astb_n  = !(strobe_on && is_addr_q);
  assign pp_dstb_n  = !(strobe_on && !is_addr_q);
  assign pp_write_n = !(active && is_wr_q);
  assign pp_data_oe = active && is_wr_q;
  assign pp_data_o  = wdat_q;
  assign hst_ack    = (state_q == ST_ACK);
  assign hst_err    = err_q;
  assign hst_rdata  = rdat_q;

  // R3: the two strobes are never low together
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    pp_astb_n || pp_dstb_n);
  // R4: the driver is only on while the write line is low
  a_r4_drive_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    pp_data_oe |-> !pp_write_n);
  // R5: a strobe starts only after wait was seen low
  a_r5_strobe_after_wait_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pp_astb_n) || $fell(pp_dstb_n)) |-> !$past(wait_s));
  // R6: the acknowledge lasts a single cycle
  a_r6_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    hst_ack |=> !hst_ack);
  // R6: no acknowledge while a strobe is still low
  a_r6_ack_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    hst_ack |-> (pp_astb_n && pp_dstb_n));
  // R8: expiry releases the pins and reports an error
  a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> (hst_ack && hst_err && pp_astb_n && pp_dstb_n && pp_write_n));
  // R9: no strobe while the timeout flag is set
  a_r9_quiet_on_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_q |-> (pp_astb_n && pp_dstb_n));
  // R7: a disabled engine never leaves idle for a peripheral cycle
  a_r7_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE) && !mode_en) |=> !active);
endmodule

// File: tb/ppx_cycle_engine_tb.sv
module ppx_cycle_engine_tb_top;
  localparam int WD = 1024;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_en = 1'b0;
  logic       hst_req = 1'b0;
  logic       hst_we = 1'b0;
  logic [1:0] hst_sel = 2'b00;
  logic [7:0] hst_wdata = 8'h00;
  logic       hst_ack, hst_err;
  logic [7:0] hst_rdata;
  logic [7:0] pp_data_i = 8'h00;
  logic [7:0] pp_data_o;
  logic       pp_data_oe, pp_write_n, pp_astb_n, pp_dstb_n;
  logic       pp_wait = 1'b0;

  int n_chk = 0, n_fail = 0;

  // peripheral model controls and records
  bit hold_high = 0, stall = 0, hold_act = 0;
  int rsp_dly = 1, rel_dly = 1, dcnt = 0, rcnt = 0;
  int astb_cnt = 0, dstb_cnt = 0, oe_cnt = 0, wn_hi_cnt = 0;
  bit last_addr = 0, last_wn = 1;
  logic [7:0] last_byte = 8'h00;

  always #2.5 clk = ~clk;

  ppx_cycle_engine #(.WDOG_CYCLES(WD), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .hst_req(hst_req),
    .hst_we(hst_we), .hst_sel(hst_sel), .hst_wdata(hst_wdata),
    .hst_ack(hst_ack), .hst_err(hst_err), .hst_rdata(hst_rdata),
    .pp_data_i(pp_data_i), .pp_data_o(pp_data_o), .pp_data_oe(pp_data_oe),
    .pp_write_n(pp_write_n), .pp_astb_n(pp_astb_n), .pp_dstb_n(pp_dstb_n),
    .pp_wait(pp_wait));

  initial begin
    forever begin
      @(negedge clk);
      if (!pp_astb_n) astb_cnt++;
      if (!pp_dstb_n) dstb_cnt++;
      if (pp_data_oe) oe_cnt++;
      if (hold_high) begin
        pp_wait = 1'b1; hold_act = 1;
      end else if (hold_act) begin
        pp_wait = 1'b0; hold_act = 0;
      end else if (!pp_wait) begin
        if ((!pp_astb_n || !pp_dstb_n) && !stall) begin
          if (dcnt >= rsp_dly) begin
            last_addr = !pp_astb_n; last_wn = pp_write_n; last_byte = pp_data_o;
            pp_wait = 1'b1; dcnt = 0;
          end else dcnt++;
        end else dcnt = 0;
      end else if (pp_astb_n && pp_dstb_n) begin
        if (rcnt >= rel_dly) begin pp_wait = 1'b0; rcnt = 0; end
        else rcnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // host access: returns data, error flag and clocks until ack
  task automatic access(input bit we, input logic [1:0] sel, input logic [7:0] wd,
                        output logic [7:0] rd, output bit er, output int n);
    @(negedge clk);
    hst_req = 1'b1; hst_we = we; hst_sel = sel; hst_wdata = wd;
    n = 0;
    do begin
      @(negedge clk); n++;
    end while (!hst_ack && n < 5000);
    rd = hst_rdata; er = hst_err;
    hst_req = 1'b0;
    @(negedge clk);
    if (n >= 5000) chk(0, "watchdog-bench", n, 0);
  endtask

  logic [7:0] rd; bit er; int n;

  task automatic t_reset();
    chk(pp_astb_n && pp_dstb_n && pp_write_n, "R1 strobes/write idle",
        {pp_astb_n, pp_dstb_n, pp_write_n}, 3'b111);
    chk(!pp_data_oe && !hst_ack, "R1 driver/ack off", {pp_data_oe, hst_ack}, 0);
    access(0, 2'b10, 8'h00, rd, er, n);
    chk(rd == 8'h00 && !er, "R1 status zero", rd, 0);
  endtask

  task automatic t_addr_write();
    int a0 = astb_cnt, d0 = dstb_cnt;
    access(1, 2'b00, 8'hA5, rd, er, n);
    chk(last_byte == 8'hA5 && last_addr && !last_wn, "R2 address write byte",
        last_byte, 8'hA5);
    chk(dstb_cnt == d0 && astb_cnt > a0 && !er, "R2 only address strobe",
        dstb_cnt - d0, 0);
  endtask

  task automatic t_data_write();
    int a0 = astb_cnt, d0 = dstb_cnt;
    rsp_dly = 3;
    access(1, 2'b01, 8'h3C, rd, er, n);
    chk(last_byte == 8'h3C && !last_addr && !er, "R3 data write byte", last_byte, 8'h3C);
    chk(astb_cnt == a0 && dstb_cnt > d0, "R3 only data strobe", astb_cnt - a0, 0);
    rsp_dly = 1;
  endtask

  task automatic t_read();
    int o0 = oe_cnt;
    pp_data_i = 8'h96;
    access(0, 2'b01, 8'hFF, rd, er, n);
    chk(rd == 8'h96 && !er, "R4 data read byte", rd, 8'h96);
    chk(oe_cnt == o0 && last_wn, "R4 no drive on read", oe_cnt - o0, 0);
    pp_data_i = 8'h5A;
    access(0, 2'b00, 8'h00, rd, er, n);
    chk(rd == 8'h5A && last_addr, "R4 address read byte", rd, 8'h5A);
  endtask

  task automatic t_wait_gate();
    int a0, d0; bit acked = 0;
    hold_high = 1;
    repeat (4) @(negedge clk);
    a0 = astb_cnt; d0 = dstb_cnt;
    hst_req = 1'b1; hst_we = 1'b1; hst_sel = 2'b01; hst_wdata = 8'h11;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (hst_ack) acked = 1;
    end
    chk(astb_cnt == a0 && dstb_cnt == d0 && !acked, "R5 no strobe while wait high",
        dstb_cnt - d0, 0);
    hold_high = 0;
    n = 0;
    do begin @(negedge clk); n++; end while (!hst_ack && n < 5000);
    er = hst_err; hst_req = 1'b0;
    @(negedge clk);
    chk(!er && last_byte == 8'h11 && n < 5000, "R5 completes after wait low", er, 0);
  endtask

  task automatic t_ack_order();
    rel_dly = 15;
    access(1, 2'b01, 8'h42, rd, er, n);
    chk(n > 17 && !er, "R6 ack waits for wait low", n, 18);
    chk(!hst_ack, "R6 ack is one pulse", hst_ack, 0);
    rel_dly = 1;
    access(1, 2'b01, 8'h43, rd, er, n);
    chk(n < 17, "R6 short release is faster", n, 16);
  endtask

  task automatic t_disabled();
    int a0 = astb_cnt, d0 = dstb_cnt;
    mode_en = 1'b0;
    access(1, 2'b01, 8'h77, rd, er, n);
    chk(er && astb_cnt == a0 && dstb_cnt == d0, "R7 refused when disabled", er, 1);
    mode_en = 1'b1;
  endtask

  task automatic t_timeout();
    stall = 1;
    access(1, 2'b01, 8'h99, rd, er, n);
    chk(n == WD + 1, "R8 abort cycle", n, WD + 1);
    chk(er, "R8 abort error", er, 1);
    chk(pp_astb_n && pp_dstb_n && pp_write_n && !pp_data_oe, "R8 pins released",
        {pp_astb_n, pp_dstb_n, pp_write_n, pp_data_oe}, 4'b1110);
    stall = 0;
    access(0, 2'b10, 8'h00, rd, er, n);
    chk(rd[0] == 1'b1, "R9 status shows timeout", rd, 1);
    chk(n == 1, "R10 status access one clock", n, 1);
  endtask

  task automatic t_refuse_clear();
    int d0 = dstb_cnt;
    access(1, 2'b01, 8'h55, rd, er, n);
    chk(er && dstb_cnt == d0, "R9 refused while timeout set", er, 1);
    access(1, 2'b10, 8'hFE, rd, er, n);
    access(0, 2'b10, 8'h00, rd, er, n);
    chk(rd[0] == 1'b1, "R9 write of 0 keeps flag", rd, 1);
    access(1, 2'b11, 8'h01, rd, er, n);
    access(0, 2'b10, 8'h00, rd, er, n);
    chk(rd[0] == 1'b0, "R9 write of 1 clears flag", rd, 0);
    access(1, 2'b01, 8'h66, rd, er, n);
    chk(!er && last_byte == 8'h66, "R9 cycles resume after clear", er, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    mode_en = 1'b1;
    t_addr_write();
    t_data_write();
    t_read();
    t_wait_gate();
    t_ack_order();
    t_disabled();
    t_timeout();
    t_refuse_clear();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog-bench actual=%0h expected=%0h", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule